// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only cache that sits between a byte-wide requester and a slower backing memory. Each request address is split into a byte offset, a set index and a tag. Both ways of the selected set are looked up at the same time: two tag comparators each produce a match, and those match signals drive a 2-to-1 byte selector. A hit returns the byte one cycle after the request is accepted.

On a miss the cache stops accepting requests. It fetches the whole line from backing memory one byte per handshake, in ascending byte order, and writes the line into the chosen way. It then returns the requested byte. The victim way is an invalid way when the set has one, with way 0 taken when both are empty. When both ways are valid, the least recently used way is replaced. One recency bit per set records which way to evict next. That bit is updated on every hit and on every fill.

The set count, line size in bytes and address width are parameters. Valid and recency state are cleared by a synchronous active-high reset.

Top module: `cache2w_top`

## Requirements
- R1: After reset `req_ready` is 1, and `resp_valid` and `mem_req` are 0. Every line is invalid, so the first access to any address is a miss.
- R2: The byte offset is address bits [OFF_W-1:0], where OFF_W = log2(LINE_BYTES). The set index is the next log2(SETS) bits, and the tag is all remaining upper bits. With 16-byte lines and 4 sets, address 6195 (0x1833) uses offset 3 and set 3, and its line occupies addresses 0x1830 to 0x183F.
- R3: On a miss the cache raises `mem_req` with `mem_addr` set to line base + k, for k = 0 .. LINE_BYTES-1 in ascending order. It advances on each cycle where `mem_req` and `mem_ack` are both 1. `resp_valid` rises in the cycle after the last handshake and carries the memory byte at the requested address.
- R4: A hit raises `resp_valid` in the cycle after acceptance with the stored byte, and it makes no memory request.
- R5: Two lines whose tags differ but whose set index is the same are held at the same time. After their two initial misses, alternating accesses to them all hit.
- R6: A miss into a set that holds one valid line fills the other, invalid way and keeps the valid line.
- R7: A miss into a set whose two ways are both valid evicts the way that was used least recently.
- R8: A hit marks its way as most recently used, so the next eviction in that set removes the other way.
- R9: Fills in one set do not disturb the lines held in any other set.
- R10: `resp_valid` is a one-cycle pulse. `req_ready` is 0 from the cycle after a miss is accepted until the response cycle, and a new request is accepted only while `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ready | output | 1 | Cache can accept a request this cycle |
| resp_valid | output | 1 | One-cycle pulse carrying the read byte |
| resp_data | output | DATA_W | Read byte |
| mem_req | output | 1 | Backing memory byte request |
| mem_addr | output | ADDR_W | Byte address requested from memory |
| mem_ack | input | 1 | Memory returns `mem_data` this cycle |
| mem_data | input | DATA_W | Byte returned by memory |

## Verification
The hardest situation to reach is a replacement decision that depends on recency rather than on validity. This requires a set whose two ways are both valid, followed by a hit that reverses the recency bit before the conflicting miss arrives. The stimulus fills one set with two tags and touches one of them again. It then brings in a third tag and probes the survivors. Hit or miss is read from the response latency and from the count of memory handshakes, so the choice of victim is observed entirely at the ports.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic hit;
        logic way;
    } lookup_t;

    // Prefer an empty way (way 0 first); otherwise take the recency pointer.
    function automatic logic pick_victim(input logic v0, input logic v1, input logic lru_way);
        if (!v0) return 1'b0;
        if (!v1) return 1'b1;
        return lru_way;
    endfunction

    function automatic lookup_t combine_match(input logic m0, input logic m1);
        lookup_t r;
        r.hit = m0 | m1;
        r.way = m1;
        return r;
    endfunction

endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
    parameter int SETS       = 4,
    parameter int LINE_BYTES = 16,
    parameter int TAG_W      = 10,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = $clog2(SETS),
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic              rd_match,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_byte_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_tag_en,
    input  logic [TAG_W-1:0]  wr_tag
);

    logic [DATA_W-1:0] data_q [SETS][LINE_BYTES];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [SETS-1:0]   valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_tag_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_tag_en) tag_q[wr_idx] <= wr_tag;
        if (wr_byte_en) data_q[wr_idx][wr_off] <= wr_data;
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_match = rd_valid && (tag_q[rd_idx] == rd_tag);
        rd_data  = data_q[rd_idx][rd_off];
    end

endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
    parameter int SETS   = 4,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_valid0,
    input  logic             rd_valid1,
    output logic             victim,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way
);
    import cache2w_pkg::*;

    // Bit per set names the way to evict next.
    logic [SETS-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else if (upd_en) begin
            older_q[upd_idx] <= ~upd_way;
        end
    end

    assign victim = pick_victim(rd_valid0, rd_valid1, older_q[rd_idx]);

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int SETS       = 4,
    parameter int LINE_BYTES = 16,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = $clog2(SETS),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  cache2w_pkg::lookup_t lk,
    input  logic              victim,
    input  logic [DATA_W-1:0] hit_byte,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data,
    output logic              fill_byte_en,
    output logic              fill_tag_en,
    output logic              fill_way,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [OFF_W-1:0]  fill_off,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              lru_upd_en,
    output logic [IDX_W-1:0]  lru_upd_idx,
    output logic              lru_upd_way
);
    import cache2w_pkg::*;

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_BYTES - 1);

    ctl_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              way_q;
    logic [OFF_W-1:0]  cnt_q;
    logic              resp_valid_q;
    logic [DATA_W-1:0] resp_data_q;

    logic accept, hit_take, miss_take, beat, last_beat;

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
        hit_take  = accept && lk.hit;
        miss_take = accept && !lk.hit;
        mem_req   = (state_q == ST_FILL);
        mem_addr  = {addr_q[ADDR_W-1:OFF_W], cnt_q};
        beat      = mem_req && mem_ack;
        last_beat = beat && (cnt_q == LAST_OFF);

        fill_byte_en = beat;
        fill_tag_en  = last_beat;
        fill_way     = way_q;
        fill_idx     = addr_q[OFF_W +: IDX_W];
        fill_off     = cnt_q;
        fill_tag     = addr_q[ADDR_W-1 -: TAG_W];

        lru_upd_en   = hit_take || last_beat;
        lru_upd_idx  = hit_take ? req_addr[OFF_W +: IDX_W] : addr_q[OFF_W +: IDX_W];
        lru_upd_way  = hit_take ? lk.way : way_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            addr_q       <= '0;
            way_q        <= 1'b0;
            cnt_q        <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (hit_take) begin
                        resp_valid_q <= 1'b1;
                        resp_data_q  <= hit_byte;
                    end else if (miss_take) begin
                        state_q <= ST_FILL;
                        addr_q  <= req_addr;
                        way_q   <= victim;
                        cnt_q   <= '0;
                    end
                end
                ST_FILL: begin
                    if (beat) begin
                        if (cnt_q == addr_q[OFF_W-1:0]) resp_data_q <= mem_data;
                        cnt_q <= cnt_q + 1'b1;
                        if (last_beat) begin
                            resp_valid_q <= 1'b1;
                            state_q      <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_data  = resp_data_q;

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top #(
    parameter int ADDR_W     = 16,
    parameter int SETS       = 4,
    parameter int LINE_BYTES = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data
);
    import cache2w_pkg::*;

    localparam int IDX_W = $clog2(SETS);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int WAYS  = 2;

    logic [IDX_W-1:0] rd_idx;
    logic [OFF_W-1:0] rd_off;
    logic [TAG_W-1:0] rd_tag;

    assign rd_off = req_addr[OFF_W-1:0];
    assign rd_idx = req_addr[OFF_W +: IDX_W];
    assign rd_tag = req_addr[ADDR_W-1 -: TAG_W];

    logic [WAYS-1:0]   way_valid;
    logic [WAYS-1:0]   way_match;
    logic [DATA_W-1:0] way_data [WAYS];

    logic              fill_byte_en, fill_tag_en, fill_way;
    logic [IDX_W-1:0]  fill_idx;
    logic [OFF_W-1:0]  fill_off;
    logic [TAG_W-1:0]  fill_tag;
    logic              lru_upd_en, lru_upd_way, victim;
    logic [IDX_W-1:0]  lru_upd_idx;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            cache2w_way #(
                .SETS(SETS), .LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W), .DATA_W(DATA_W)
            ) i_way (
                .clk        (clk),
                .rst        (rst),
                .rd_idx     (rd_idx),
                .rd_off     (rd_off),
                .rd_tag     (rd_tag),
                .rd_valid   (way_valid[w]),
                .rd_match   (way_match[w]),
                .rd_data    (way_data[w]),
                .wr_byte_en (fill_byte_en && (fill_way == 1'(w))),
                .wr_idx     (fill_idx),
                .wr_off     (fill_off),
                .wr_data    (mem_data),
                .wr_tag_en  (fill_tag_en && (fill_way == 1'(w))),
                .wr_tag     (fill_tag)
            );
        end
    endgenerate

    lookup_t           lk;
    logic              lk_hit;
    logic [DATA_W-1:0] hit_byte;

    assign lk       = combine_match(way_match[0], way_match[1]);
    assign lk_hit   = lk.hit;
    assign hit_byte = lk.way ? way_data[1] : way_data[0];

    cache2w_lru #(.SETS(SETS)) i_lru (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (rd_idx),
        .rd_valid0 (way_valid[0]),
        .rd_valid1 (way_valid[1]),
        .victim    (victim),
        .upd_en    (lru_upd_en),
        .upd_idx   (lru_upd_idx),
        .upd_way   (lru_upd_way)
    );

    cache2w_ctrl #(
        .ADDR_W(ADDR_W), .SETS(SETS), .LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W)
    ) i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_ready    (req_ready),
        .lk           (lk),
        .victim       (victim),
        .hit_byte     (hit_byte),
        .resp_valid   (resp_valid),
        .resp_data    (resp_data),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_ack      (mem_ack),
        .mem_data     (mem_data),
        .fill_byte_en (fill_byte_en),
        .fill_tag_en  (fill_tag_en),
        .fill_way     (fill_way),
        .fill_idx     (fill_idx),
        .fill_off     (fill_off),
        .fill_tag     (fill_tag),
        .lru_upd_en   (lru_upd_en),
        .lru_upd_idx  (lru_upd_idx),
        .lru_upd_way  (lru_upd_way)
    );

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              lk_hit,
    input logic [1:0]        way_match
);

    p_idle_no_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req);

    p_fetch_starts_base_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> (mem_addr[OFF_W-1:0] == '0));

    p_fetch_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_fill_resp_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && (mem_addr[OFF_W-1:0] == OFF_W'(LINE_BYTES - 1)))
        |=> (resp_valid && req_ready));

    p_hit_resp_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && lk_hit) |=> (resp_valid && !mem_req));

    p_single_way_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_match));

    p_resp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    p_miss_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !lk_hit) |=> !req_ready);

endmodule

bind cache2w_top cache2w_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .lk_hit     (lk_hit),
    .way_match  (way_match)
);

// File: tb/test_cache2w_top.sv
`timescale 1ns/1ps
module test_cache2w_top;
    localparam int ADDR_W = 16;
    localparam int SETS   = 4;
    localparam int LINE   = 16;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready, resp_valid, mem_req;
    logic [DATA_W-1:0] resp_data;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int ack_cnt = 0;
    int seq_err = 0;
    int burst_i = 0;
    int cyc     = 0;
    logic [ADDR_W-1:0] exp_base = '0;

    always #4 clk = ~clk;

    cache2w_top #(.ADDR_W(ADDR_W), .SETS(SETS), .LINE_BYTES(LINE), .DATA_W(DATA_W)) i_cache2w_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_data(resp_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data)
    );

    function automatic logic [7:0] mem_val(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // Backing memory: acknowledges every other cycle.
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack  <= 1'b1;
            mem_data <= mem_val(mem_addr);
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_ack) begin
            ack_cnt <= ack_cnt + 1;
            if (mem_addr != exp_base + ADDR_W'(burst_i)) seq_err <= seq_err + 1;
            burst_i <= (burst_i == LINE - 1) ? 0 : burst_i + 1;
        end
        if (cyc > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<100000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, output int data, output int lat,
                          output int fetches, output int rdy_after, output int pulse_after);
        int start;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_base  = {a[ADDR_W-1:4], 4'h0};
        req_valid = 1'b1;
        req_addr  = a;
        start     = ack_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        rdy_after = int'(req_ready);
        lat = 1;
        while (!resp_valid && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        data    = int'(resp_data);
        fetches = ack_cnt - start;
        @(negedge clk);
        pulse_after = int'(resp_valid);
    endtask

    task automatic expect_hit(input logic [ADDR_W-1:0] a, input string req);
        int d, l, f, r, p;
        access(a, d, l, f, r, p);
        check(l == 1 && f == 0, {req, " hit latency/fetches"}, l * 100 + f, 100);
        check(d == int'(mem_val(a)), {req, " hit data"}, d, int'(mem_val(a)));
    endtask

    task automatic expect_miss(input logic [ADDR_W-1:0] a, input string req);
        int d, l, f, r, p, e0;
        e0 = seq_err;
        access(a, d, l, f, r, p);
        check(l == 2 * LINE && f == LINE, {req, " miss latency/fetches"}, l * 100 + f, 2 * LINE * 100 + LINE);
        check(d == int'(mem_val(a)), {req, " miss data"}, d, int'(mem_val(a)));
        check(seq_err == e0, "R3 fetch address order", seq_err - e0, 0);
        check(r == 0 && p == 0, "R10 stall and pulse", r * 10 + p, 0);
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R1 resp idle after reset", int'(resp_valid), 0);
        check(mem_req == 1'b0, "R1 mem_req idle after reset", int'(mem_req), 0);
        expect_miss(16'h0020, "R1 first access");
    endtask

    task automatic t_hit_r4();
        expect_hit(16'h0025, "R4 same line");
        expect_hit(16'h002F, "R4 last byte");
    endtask

    task automatic t_split_r2();
        expect_miss(16'd6195, "R2 addr 6195");
        expect_hit(16'h1830, "R2 same line base");
        expect_hit(16'h183F, "R2 same line top");
        expect_miss(16'h1840, "R2 next line");
    endtask

    task automatic t_two_ways_r5();
        expect_miss(16'h0060, "R5 second tag");
        expect_hit(16'h0020, "R5 alternate A");
        expect_hit(16'h0060, "R5 alternate B");
        expect_hit(16'h0021, "R5 alternate A again");
    endtask

    task automatic t_invalid_first_r6();
        expect_miss(16'h0000, "R6 first tag set0");
        expect_miss(16'h0040, "R6 second tag set0");
        expect_hit(16'h0003, "R6 first line kept");
    endtask

    task automatic t_lru_r7_r8();
        // Set 2 holds 0x0020 (most recent) and 0x0060.
        expect_miss(16'h00A0, "R7 third tag evicts older");
        expect_hit(16'h0020, "R8 recently used survives");
        expect_miss(16'h0060, "R7 older line was evicted");
        expect_miss(16'h00A0, "R8 hit redirected eviction");
    endtask

    task automatic t_sets_r9();
        expect_hit(16'h1833, "R9 set3 line untouched");
        expect_hit(16'h0044, "R9 set0 line untouched");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_r1();
        t_hit_r4();
        t_split_r2();
        t_two_ways_r5();
        t_invalid_first_r6();
        t_lru_r7_r8();
        t_sets_r9();
        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule